// File: doc/BRIEF.md
# Front-End Configuration and Control Fan-Out Driver

This block sits between a host register port and fifteen front-end readout channels. Each channel gets five lines: a clock, a combined trigger/serial-data line, a serial-load strobe, a test pulse and an active-low reset. During normal running the block copies the incoming trigger, test pulse and reset to every channel. It counts trigger pulses, and it lets the test pulse through only on the channels the host has enabled in a mask.

To configure the chips, the host writes a 20-bit configuration word, picks a channel and starts a download. The block then shifts the word out on the shared trigger/data line, most significant bit first, one bit per clock. After the shift it fires a single-cycle load strobe on the chosen channel only. That channel's chips capture the word. Each channel holds five chained chips, and the chips tell their own words apart by a 6-bit address field carried inside the word. All of the block's state can be read back through the same register port.

Top module: `fe_ctl_driver`

## Requirements
- R1: After reset the word, channel-select, control, mask and trigger-count registers read 0, busy reads 0, no serial-load strobe is active, and the trigger/data and reset outputs follow their inputs.
- R2: Every channel's trigger/data output equals the incoming trigger ORed with the internal serial-data bit, which is 0 except while a word is shifting.
- R3: Once a start is accepted at clock edge E, the shared data line carries word bit 19-j during cycle E+j for j = 0..19. The line is 0 in cycle E+20. In cycle E+21 only the selected channel's serial-load line is high, for one cycle. Cycle E+22 is idle, and busy (status bit 0) reads 1 through E+22 and 0 from E+23.
- R4: A start is a write to address 2 with bits 0 and 1 both set. It is accepted only while busy is 0. Any other start attempt leaves busy at 0 or leaves the running sequence unchanged, and produces no extra load strobe.
- R5: The channel-select register (address 1, bits 3:0) accepts the values 0 to 14. A write of 15 leaves the previous value in place.
- R6: A channel's test-pulse output is the incoming test pulse ANDed with that channel's bit in the 15-bit mask (address 3, bit i for channel i).
- R7: Every channel's reset output is low when the external reset input is low, or when download mode (address 2 bit 1) and the internal reset request (address 2 bit 2) are both set. With download mode clear, the external reset passes through unchanged.
- R8: The trigger counter (address 4) counts rising edges of the trigger input, holds 16 bits, wraps from 65535 to 0, and is cleared by any write to address 4.
- R9: Reads return the word at address 0, the select at 1, the control bits at 2 (bit 0 reads 0), the mask at 3, the count at 4 and busy at address 5 bit 0.
- R10: Every channel's clock output follows the front-end clock input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz block clock |
| rst_n | input | 1 | Active-low block reset |
| host_wr | input | 1 | Register write enable |
| host_addr | input | 3 | Register address |
| host_wdata | input | 20 | Register write data |
| host_rdata | output | 20 | Register read data (combinational on address) |
| fe_clk_in | input | 1 | Front-end clock to fan out |
| trig_in | input | 1 | Incoming trigger |
| tp_in | input | 1 | Incoming test pulse |
| ext_nrst_in | input | 1 | Incoming active-low front-end reset |
| ch_clk | output | 15 | Per-channel clock |
| ch_trig | output | 15 | Per-channel trigger / serial data |
| ch_sload | output | 15 | Per-channel serial-load strobe |
| ch_tp | output | 15 | Per-channel masked test pulse |
| ch_nrst | output | 15 | Per-channel active-low reset |

## Verification
A fault in the shift register or the bit counter shows up on the trigger/data lines within the 20-cycle shift window. It appears either as a wrong bit in a given cycle or as a load strobe that comes early or late against the R3 cycle count. A corrupted select latch or sequencer state puts the strobe on the wrong channel, or on none, in cycle E+21. Busy is read back, so a stuck state is also seen from cycle E+23 on. A counter that miscounts, saturates or fails to wrap differs at the next read of address 4.

// File: rtl/fe_ctl_pkg.sv
`timescale 1ns/1ps
package fe_ctl_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SHIFT,
    SQ_PRE,
    SQ_LOAD,
    SQ_POST
  } sq_state_t;

  localparam logic [2:0] A_WORD = 3'd0;
  localparam logic [2:0] A_SEL  = 3'd1;
  localparam logic [2:0] A_CTRL = 3'd2;
  localparam logic [2:0] A_MASK = 3'd3;
  localparam logic [2:0] A_TCNT = 3'd4;
  localparam logic [2:0] A_STAT = 3'd5;

  localparam int CTRL_START = 0;
  localparam int CTRL_DLM   = 1;
  localparam int CTRL_RSTQ  = 2;

endpackage

// File: rtl/fe_trig_count.sv
`timescale 1ns/1ps
module fe_trig_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_in,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);

  logic trig_q;
  logic trig_edge;

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  assign trig_edge = trig_in & ~trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      count  <= '0;
    end else begin
      trig_q <= trig_in;
      if (clr)
        count <= '0;
      else if (trig_edge)
        count <= cnt_step(count);
    end
  end

  // R8: clear takes effect on the next edge
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

  // R8: without an edge or a clear the count holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_edge && !clr) |=> $stable(count));

endmodule

// File: rtl/fe_host_regs.sv
`timescale 1ns/1ps
module fe_host_regs
  import fe_ctl_pkg::*;
#(
  parameter int N_CH   = 15,
  parameter int WORD_W = 20,
  parameter int CNT_W  = 16,
  parameter int HW     = 20,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [2:0]        host_addr,
  input  logic [HW-1:0]     host_wdata,
  output logic [HW-1:0]     host_rdata,
  input  logic              busy,
  input  logic [CNT_W-1:0]  trig_count,
  output logic              cnt_clr,
  output logic              start_go,
  output logic [WORD_W-1:0] word_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic [N_CH-1:0]   mask_q,
  output logic              dl_mode,
  output logic              rst_req
);

  localparam logic [SEL_W-1:0] LAST_CH = SEL_W'(N_CH - 1);

  logic wr_word, wr_sel, wr_ctrl, wr_mask;
  logic sel_ok;

  function automatic logic sel_valid(input logic [SEL_W-1:0] v);
    return v <= LAST_CH;
  endfunction

  assign wr_word = host_wr && (host_addr == A_WORD);
  assign wr_sel  = host_wr && (host_addr == A_SEL);
  assign wr_ctrl = host_wr && (host_addr == A_CTRL);
  assign wr_mask = host_wr && (host_addr == A_MASK);
  assign cnt_clr = host_wr && (host_addr == A_TCNT);
  assign sel_ok  = sel_valid(host_wdata[SEL_W-1:0]);

  assign start_go = wr_ctrl && host_wdata[CTRL_START] && host_wdata[CTRL_DLM] && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      sel_q   <= '0;
      mask_q  <= '0;
      dl_mode <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (wr_word) word_q <= host_wdata[WORD_W-1:0];
      if (wr_sel && sel_ok) sel_q <= host_wdata[SEL_W-1:0];
      if (wr_mask) mask_q <= host_wdata[N_CH-1:0];
      if (wr_ctrl) begin
        dl_mode <= host_wdata[CTRL_DLM];
        rst_req <= host_wdata[CTRL_RSTQ];
      end
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_WORD: host_rdata = HW'(word_q);
      A_SEL:  host_rdata = HW'(sel_q);
      A_CTRL: host_rdata = HW'({rst_req, dl_mode, 1'b0});
      A_MASK: host_rdata = HW'(mask_q);
      A_TCNT: host_rdata = HW'(trig_count);
      A_STAT: host_rdata = HW'(busy);
      default: host_rdata = '0;
    endcase
  end

  // R5: the select register never holds a channel that does not exist
  a_r5_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q <= LAST_CH);

  // R5: an out-of-range select write leaves the register untouched
  a_r5_bad_sel_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && !sel_ok) |=> $stable(sel_q));

endmodule

// File: rtl/fe_dl_seq.sv
`timescale 1ns/1ps
module fe_dl_seq
  import fe_ctl_pkg::*;
#(
  parameter int N_CH   = 15,
  parameter int WORD_W = 20,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_go,
  input  logic [WORD_W-1:0] word,
  input  logic [SEL_W-1:0]  sel,
  output logic              ser_data,
  output logic [N_CH-1:0]   sload,
  output logic              busy
);

  localparam int CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST_BIT = CW'(WORD_W - 1);

  sq_state_t         state;
  logic [CW-1:0]     bit_cnt;
  logic [WORD_W-1:0] sr;
  logic [SEL_W-1:0]  sel_l;
  logic              load_phase;

  function automatic logic [N_CH-1:0] chan_onehot(input logic [SEL_W-1:0] s);
    logic [N_CH-1:0] v;
    v = '0;
    for (int i = 0; i < N_CH; i++)
      if (s == SEL_W'(i)) v[i] = 1'b1;
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      bit_cnt <= '0;
      sr      <= '0;
      sel_l   <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (start_go) begin
          sr      <= word;
          sel_l   <= sel;
          bit_cnt <= '0;
          state   <= SQ_SHIFT;
        end
        SQ_SHIFT: begin
          sr <= sr << 1;
          if (bit_cnt == LAST_BIT) state <= SQ_PRE;
          else bit_cnt <= bit_cnt + CW'(1);
        end
        SQ_PRE:  state <= SQ_LOAD;
        SQ_LOAD: state <= SQ_POST;
        SQ_POST: state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign load_phase = (state == SQ_LOAD);
  assign ser_data   = (state == SQ_SHIFT) & sr[WORD_W-1];
  assign sload      = load_phase ? chan_onehot(sel_l) : '0;
  assign busy       = (state != SQ_IDLE);

  // R3: at most one channel strobed at a time
  a_r3_one_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sload));

  // R3: the data line is idle while a channel captures
  a_r3_quiet_at_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sload != '0) |-> !ser_data);

  // R3: the load strobe lasts one cycle
  a_r3_load_single: assert property (@(posedge clk) disable iff (!rst_n)
    (sload != '0) |=> (sload == '0));

  // R4: the register block only issues a start while idle
  a_r4_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |-> !busy);

endmodule

// File: rtl/fe_chan_fanout.sv
`timescale 1ns/1ps
module fe_chan_fanout #(
  parameter int N_CH = 15
) (
  input  logic            fe_clk_in,
  input  logic            trig_in,
  input  logic            ser_data,
  input  logic            tp_in,
  input  logic            ext_nrst_in,
  input  logic            int_nrst,
  input  logic [N_CH-1:0] mask,
  input  logic [N_CH-1:0] sload,
  output logic [N_CH-1:0] ch_clk,
  output logic [N_CH-1:0] ch_trig,
  output logic [N_CH-1:0] ch_sload,
  output logic [N_CH-1:0] ch_tp,
  output logic [N_CH-1:0] ch_nrst
);

  logic trig_mix;
  logic nrst_mix;

  assign trig_mix = trig_in | ser_data;
  assign nrst_mix = ext_nrst_in & int_nrst;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign ch_clk[g]   = fe_clk_in;
    assign ch_trig[g]  = trig_mix;
    assign ch_sload[g] = sload[g];
    assign ch_tp[g]    = tp_in & mask[g];
    assign ch_nrst[g]  = nrst_mix;
  end

endmodule

// File: rtl/fe_ctl_driver.sv
`timescale 1ns/1ps
module fe_ctl_driver #(
  parameter int N_CH   = 15,
  parameter int WORD_W = 20,
  parameter int CNT_W  = 16,
  parameter int HW     = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_wr,
  input  logic [2:0]      host_addr,
  input  logic [HW-1:0]   host_wdata,
  output logic [HW-1:0]   host_rdata,
  input  logic            fe_clk_in,
  input  logic            trig_in,
  input  logic            tp_in,
  input  logic            ext_nrst_in,
  output logic [N_CH-1:0] ch_clk,
  output logic [N_CH-1:0] ch_trig,
  output logic [N_CH-1:0] ch_sload,
  output logic [N_CH-1:0] ch_tp,
  output logic [N_CH-1:0] ch_nrst
);

  localparam int SEL_W = $clog2(N_CH);

  logic              busy, start_go, cnt_clr, dl_mode, rst_req, ser_data, int_nrst;
  logic [WORD_W-1:0] word_q;
  logic [SEL_W-1:0]  sel_q;
  logic [N_CH-1:0]   mask_q, sload;
  logic [CNT_W-1:0]  trig_count;

  assign int_nrst = ~(dl_mode & rst_req);

  fe_host_regs #(.N_CH(N_CH), .WORD_W(WORD_W), .CNT_W(CNT_W), .HW(HW), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
    .trig_count(trig_count), .cnt_clr(cnt_clr), .start_go(start_go),
    .word_q(word_q), .sel_q(sel_q), .mask_q(mask_q),
    .dl_mode(dl_mode), .rst_req(rst_req)
  );

  fe_trig_count #(.CNT_W(CNT_W)) u_tcnt (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .clr(cnt_clr), .count(trig_count)
  );

  fe_dl_seq #(.N_CH(N_CH), .WORD_W(WORD_W), .SEL_W(SEL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_go(start_go), .word(word_q), .sel(sel_q),
    .ser_data(ser_data), .sload(sload), .busy(busy)
  );

  fe_chan_fanout #(.N_CH(N_CH)) u_fan (
    .fe_clk_in(fe_clk_in), .trig_in(trig_in), .ser_data(ser_data), .tp_in(tp_in),
    .ext_nrst_in(ext_nrst_in), .int_nrst(int_nrst), .mask(mask_q), .sload(sload),
    .ch_clk(ch_clk), .ch_trig(ch_trig), .ch_sload(ch_sload), .ch_tp(ch_tp),
    .ch_nrst(ch_nrst)
  );

  // R7: outside download mode the external reset reaches every channel unchanged
  a_r7_ext_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !dl_mode |-> (ch_nrst == {N_CH{ext_nrst_in}}));

  // R2: with no trigger and no shifting, the trigger/data lines stay low
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !trig_in) |-> (ch_trig == '0));

endmodule

// File: tb/tb_fe_ctl_driver.sv
`timescale 1ns/1ps
module tb_fe_ctl_driver;

  localparam int CLK_P = 100;
  localparam int N = 15;
  localparam logic [14:0] ALL = 15'h7FFF;

  logic        clk = 0, rst_n = 0, host_wr = 0;
  logic [2:0]  host_addr = 0;
  logic [19:0] host_wdata = 0, host_rdata;
  logic        fe_clk_in = 0, trig_in = 0, tp_in = 0, ext_nrst_in = 1;
  logic [14:0] ch_clk, ch_trig, ch_sload, ch_tp, ch_nrst;

  int total = 0, bad = 0;
  bit done = 0;

  fe_ctl_driver dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .fe_clk_in(fe_clk_in),
    .trig_in(trig_in), .tp_in(tp_in), .ext_nrst_in(ext_nrst_in),
    .ch_clk(ch_clk), .ch_trig(ch_trig), .ch_sload(ch_sload), .ch_tp(ch_tp),
    .ch_nrst(ch_nrst)
  );

  always #(CLK_P/2) clk = ~clk;

  // vector table: mask, tp, trig, ext_nrst -> expected tp, trig, nrst outputs
  localparam logic [14:0] V_MASK [6] = '{15'h7FFF, 15'h7FFF, 15'h5555, 15'h2AAA, 15'h0000, 15'h4001};
  localparam logic        V_TP   [6] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic        V_TRIG [6] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic        V_NRST [6] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [14:0] E_TP   [6] = '{15'h7FFF, 15'h0000, 15'h5555, 15'h2AAA, 15'h0000, 15'h4001};
  localparam logic [14:0] E_TRIG [6] = '{15'h0000, 15'h7FFF, 15'h0000, 15'h7FFF, 15'h0000, 15'h0000};
  localparam logic [14:0] E_NRST [6] = '{15'h7FFF, 15'h7FFF, 15'h0000, 15'h7FFF, 15'h7FFF, 15'h7FFF};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic hw(input logic [2:0] a, input logic [19:0] d);
    host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [19:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  // runs a full download and checks the R3 timeline; trig pulse injected at bit trig_at (-1 none)
  task automatic download(input logic [19:0] w, input int ch, input int trig_at);
    logic [19:0] r;
    hw(3'd0, w);
    hw(3'd1, 20'(ch));
    hw(3'd2, 20'h3);            // after edge E
    for (int j = 0; j < 20; j++) begin
      if (j == trig_at) begin
        trig_in = 1; #1;
        chk("R2 trig OR data", ch_trig, ALL);
        trig_in = 0; #1;
      end
      chk("R3 shift bit", ch_trig, w[19-j] ? ALL : 15'h0);
      chk("R3 no early load", ch_sload, 15'h0);
      @(negedge clk);
    end
    chk("R3 pre gap data", ch_trig, 15'h0);
    chk("R3 pre gap load", ch_sload, 15'h0);
    rd(3'd5, r); chk("R3 busy during", r, 20'h1);
    @(negedge clk);
    chk("R3 load strobe", ch_sload, 15'(1) << ch);
    @(negedge clk);
    chk("R3 post gap load", ch_sload, 15'h0);
    rd(3'd5, r); chk("R3 busy post gap", r, 20'h1);
    @(negedge clk);
    rd(3'd5, r); chk("R3 busy cleared", r, 20'h0);
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [19:0] r;
    int hits, where;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), r); chk("R1 reset readback", r, 20'h0);
    end
    chk("R1 no load", ch_sload, 15'h0);
    chk("R1 nrst follows", ch_nrst, ALL);
    tp_in = 1; #1; chk("R1 mask cleared", ch_tp, 15'h0); tp_in = 0;

    // R10 clock fan-out
    fe_clk_in = 1; #1; chk("R10 clock high", ch_clk, ALL);
    fe_clk_in = 0; #1; chk("R10 clock low", ch_clk, 15'h0);

    // table walk: R2, R6, R7
    for (int v = 0; v < 6; v++) begin
      hw(3'd3, 20'(V_MASK[v]));
      tp_in = V_TP[v]; trig_in = V_TRIG[v]; ext_nrst_in = V_NRST[v];
      #1;
      chk("R6 test pulse mask", ch_tp, E_TP[v]);
      chk("R2 trigger fan-out", ch_trig, E_TRIG[v]);
      chk("R7 external reset", ch_nrst, E_NRST[v]);
      @(negedge clk);
    end
    tp_in = 0; trig_in = 0; ext_nrst_in = 1;

    // R9 readback
    hw(3'd0, 20'hA5C3E); rd(3'd0, r); chk("R9 word readback", r, 20'hA5C3E);
    hw(3'd3, 20'h1234);  rd(3'd3, r); chk("R9 mask readback", r, 20'h1234);
    hw(3'd1, 20'd9);     rd(3'd1, r); chk("R9 select readback", r, 20'd9);
    // R5 invalid select
    hw(3'd1, 20'd15);    rd(3'd1, r); chk("R5 select 15 ignored", r, 20'd9);
    hw(3'd1, 20'd14);    rd(3'd1, r); chk("R5 select 14 kept", r, 20'd14);

    // R7 internal reset
    hw(3'd2, 20'h4);  rd(3'd2, r); chk("R9 ctrl readback", r, 20'h4);
    chk("R7 req without mode", ch_nrst, ALL);
    hw(3'd2, 20'h6);  chk("R7 internal reset", ch_nrst, 15'h0);
    hw(3'd2, 20'h2);  chk("R7 reset released", ch_nrst, ALL);
    hw(3'd2, 20'h0);

    // R4 start without download mode
    hw(3'd0, 20'hFFFFF); hw(3'd2, 20'h1);
    rd(3'd5, r); chk("R4 start no mode", r, 20'h0);
    hits = 0;
    for (int k = 0; k < 25; k++) begin
      if (ch_sload != 0 || ch_trig != 0) hits++;
      @(negedge clk);
    end
    chk("R4 nothing shifted", 32'(hits), 32'd0);

    // R3 downloads, boundary channels
    download(20'hB3A5C, 14, -1);
    download(20'h00000, 0, 7);
    download(20'h80001, 5, -1);

    // R4 start while busy
    hw(3'd1, 20'd3);
    hw(3'd2, 20'h3);            // after E
    repeat (5) @(negedge clk);  // after E+5
    hw(3'd1, 20'd8);            // select changes, shift keeps latched channel
    hw(3'd2, 20'h3);            // after E+7, ignored
    hits = 0; where = -1;
    for (int k = 7; k < 40; k++) begin
      if (ch_sload != 0) begin hits++; where = k; end
      if (ch_sload != 0) chk("R4 latched channel", ch_sload, 15'h0008);
      @(negedge clk);
    end
    chk("R4 single strobe", 32'(hits), 32'd1);
    chk("R3 strobe cycle", 32'(where), 32'd21);
    rd(3'd5, r); chk("R4 idle after", r, 20'h0);
    hw(3'd2, 20'h0);

    // R8 trigger counter
    hw(3'd4, 20'h0);
    for (int k = 0; k < 3; k++) begin
      trig_in = 1; @(negedge clk); trig_in = 0; @(negedge clk);
    end
    rd(3'd4, r); chk("R8 count pulses", r, 20'd3);
    trig_in = 1; repeat (4) @(negedge clk); trig_in = 0; @(negedge clk);
    rd(3'd4, r); chk("R8 long pulse once", r, 20'd4);
    hw(3'd4, 20'h0); rd(3'd4, r); chk("R8 clear", r, 20'd0);
    for (int k = 0; k < 65536; k++) begin
      trig_in = 1; @(negedge clk); trig_in = 0; @(negedge clk);
    end
    rd(3'd4, r); chk("R8 wrap to zero", r, 20'd0);
    trig_in = 1; @(negedge clk); trig_in = 0; @(negedge clk);
    rd(3'd4, r); chk("R8 after wrap", r, 20'd1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule